// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps the single reservation that backs a load-linked / store-conditional pair in one processor's coherent data cache. It watches the local request stream (plain loads, plain stores, load-linked and store-conditional) and decides in the same cycle whether a store-conditional may write. It also produces the 1-or-0 value destined for the store-conditional's register.

The reservation is a cache-line tag plus a valid bit. Only coherence events drop it: a remote read-for-ownership snoop, an eviction of the reserved line, an explicit clear pulse (exception or context switch), or reset. Data values are never compared, so a value that changes and then changes back still makes the store-conditional fail. A store that the monitor permits raises an ownership-upgrade strobe only when the cache does not already hold the line. An uncontended pair on a locally held line therefore makes no bus request.

Top module: `llsc_resv_monitor`

## Requirements
- R1: reqOp encodes 0 = plain load, 1 = plain store, 2 = load-linked, 3 = store-conditional. A plain store always gets wrEnable=1, a plain load never does, and neither kind creates, changes or drops a reservation.
- R2: A load-linked saves bits [31:5] of reqAddr (32-byte lines) as the reservation tag and sets resvValid on the next cycle.
- R3: A store-conditional succeeds (wrEnable=1, scResult=1) exactly when resvValid is set and its address lies in the reserved line. Any word of that line qualifies.
- R4: scValid is high for every store-conditional. scResult is 1 on success and 0 on failure, and wrEnable stays 0 for a failed store-conditional.
- R5: A store-conditional issued with no valid reservation always fails.
- R6: Every store-conditional, successful or not, leaves resvValid cleared on the next cycle.
- R7: A snoop with snoopRfo=1 whose address lies in the reserved line clears the reservation. A snoop with snoopRfo=0, or a snoop to another line, leaves it intact.
- R8: A clearing event (hitting RFO snoop, hitting eviction, or clearResv) in the same cycle as a store-conditional wins, and the store-conditional fails. The same events aimed at a load-linked's own line in its cycle stop the new reservation from being set.
- R9: An eviction of the reserved line, a clearResv pulse and reset each leave resvValid at 0.
- R10: A new load-linked replaces the old reservation. Afterwards, only the newest line lets a store-conditional succeed.
- R11: busUpgrade is high exactly when wrEnable is high and lineOwned is low, so a successful store-conditional to a locally owned line makes no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Local request present |
| reqOp | input | 2 | Request kind (see R1) |
| reqAddr | input | ADDR_W | Physical address of the request |
| lineOwned | input | 1 | Cache holds the request's line with write ownership |
| snoopValid | input | 1 | Remote snoop present |
| snoopRfo | input | 1 | Snoop is a read-for-ownership |
| snoopAddr | input | ADDR_W | Snoop physical address |
| evictValid | input | 1 | Local cache is evicting a line |
| evictAddr | input | ADDR_W | Address of the evicted line |
| clearResv | input | 1 | Exception / context-switch clear pulse |
| wrEnable | output | 1 | Store may update the cache |
| scValid | output | 1 | Current request is a store-conditional |
| scResult | output | 1 | Destination value of the store-conditional |
| busUpgrade | output | 1 | Ownership request needed for a permitted store |
| resvValid | output | 1 | Reservation currently held |

## Verification
The assertions check on every cycle that:
- a store-conditional without a reservation fails;
- every store-conditional leaves the reservation empty;
- a same-cycle clearing event defeats the store-conditional;
- an RFO snoop hit or a clear pulse drops the reservation;
- plain traffic leaves the valid bit alone;
- the upgrade strobe never accompanies a permitted write to an owned line.

The bench sweeps every combination of request kind, request line and word, snoop kind, eviction, clear pulse and line ownership, each after a fresh load-linked. It then probes the surviving tag with a follow-up store-conditional. Only these scenarios show that the right line is kept, that a different word in the same line succeeds, and that a replacing load-linked moves the tag.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } reqOpE;

  typedef struct packed {
    logic loadTag;
  } resvCtrlT;
endpackage

// File: rtl/llsc_resv_dp.sv
module llsc_resv_dp #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  llsc_pkg::resvCtrlT    ctrl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [ADDR_W-1:0]     snoopAddr,
  input  logic [ADDR_W-1:0]     evictAddr,
  output logic                  reqHit,
  output logic                  snoopHit,
  output logic                  evictHit,
  output logic                  snoopOnReq,
  output logic                  evictOnReq
);
  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int TAG_W  = ADDR_W - OFFS_W;

  logic [TAG_W-1:0] tagQ;
  logic [TAG_W-1:0] reqTag, snoopTag, evictTag;

  assign reqTag   = reqAddr[ADDR_W-1:OFFS_W];
  assign snoopTag = snoopAddr[ADDR_W-1:OFFS_W];
  assign evictTag = evictAddr[ADDR_W-1:OFFS_W];

  always_ff @(posedge clk) begin
    if (!rstN)             tagQ <= '0;
    else if (ctrl.loadTag) tagQ <= reqTag;
  end

  assign reqHit     = (reqTag == tagQ);
  assign snoopHit   = (snoopTag == tagQ);
  assign evictHit   = (evictTag == tagQ);
  assign snoopOnReq = (snoopTag == reqTag);
  assign evictOnReq = (evictTag == reqTag);

  // R2: a loaded tag matches the same request address on the next cycle
  AST_TAG_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadTag |=> (tagQ == $past(reqTag)));  // R2
endmodule

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic               lineOwned,
  input  logic               snoopValid,
  input  logic               snoopRfo,
  input  logic               evictValid,
  input  logic               clearResv,
  input  logic               reqHit,
  input  logic               snoopHit,
  input  logic               evictHit,
  input  logic               snoopOnReq,
  input  logic               evictOnReq,
  output llsc_pkg::resvCtrlT dpCtrl,
  output logic               wrEnable,
  output logic               scValid,
  output logic               scResult,
  output logic               busUpgrade,
  output logic               resvValid
);
  import llsc_pkg::*;

  reqOpE op;
  logic  isLoad, isStore, isLl, isSc;
  logic  killOld, killNew, scOk;
  logic  validQ, validD;

  assign op      = reqOpE'(reqOp);
  assign isLoad  = reqValid && (op == OP_LOAD);
  assign isStore = reqValid && (op == OP_STORE);
  assign isLl    = reqValid && (op == OP_LL);
  assign isSc    = reqValid && (op == OP_SC);

  // Clearing events against the held line, and against the line a load-linked targets
  assign killOld = clearResv || (snoopValid && snoopRfo && snoopHit)
                             || (evictValid && evictHit);
  assign killNew = clearResv || (snoopValid && snoopRfo && snoopOnReq)
                             || (evictValid && evictOnReq);

  assign scOk = isSc && validQ && reqHit && !killOld;

  always_comb begin
    if (isLl)      validD = !killNew;
    else if (isSc) validD = 1'b0;
    else           validD = validQ && !killOld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= validD;
  end

  assign dpCtrl.loadTag = isLl;
  assign wrEnable   = isStore || scOk;
  assign scValid    = isSc;
  assign scResult   = scOk;
  assign busUpgrade = wrEnable && !lineOwned;
  assign resvValid  = validQ;

  AST_SC_NO_RESV: assert property (@(posedge clk) disable iff (!rstN)
    (isSc && !resvValid) |-> !scResult);  // R5
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    isSc |=> !resvValid);  // R6
  AST_RFO_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && snoopRfo && snoopHit && !isLl) |=> !resvValid);  // R7
  AST_KILL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (isSc && killOld) |-> (!scResult && !wrEnable));  // R8
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    clearResv |=> !resvValid);  // R9
  AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ((isLoad || isStore) && !killOld) |=> $stable(resvValid));  // R1
  AST_OWNED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (scResult && lineOwned) |-> !busUpgrade);  // R11
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              lineOwned,
  input  logic              snoopValid,
  input  logic              snoopRfo,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic              clearResv,
  output logic              wrEnable,
  output logic              scValid,
  output logic              scResult,
  output logic              busUpgrade,
  output logic              resvValid
);
  llsc_pkg::resvCtrlT dpCtrl;
  logic reqHit, snoopHit, evictHit, snoopOnReq, evictOnReq;

  llsc_resv_dp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl),
    .reqAddr(reqAddr), .snoopAddr(snoopAddr), .evictAddr(evictAddr),
    .reqHit(reqHit), .snoopHit(snoopHit), .evictHit(evictHit),
    .snoopOnReq(snoopOnReq), .evictOnReq(evictOnReq)
  );

  llsc_resv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .lineOwned(lineOwned), .snoopValid(snoopValid), .snoopRfo(snoopRfo),
    .evictValid(evictValid), .clearResv(clearResv),
    .reqHit(reqHit), .snoopHit(snoopHit), .evictHit(evictHit),
    .snoopOnReq(snoopOnReq), .evictOnReq(evictOnReq),
    .dpCtrl(dpCtrl), .wrEnable(wrEnable), .scValid(scValid),
    .scResult(scResult), .busUpgrade(busUpgrade), .resvValid(resvValid)
  );
endmodule

// File: tb/test_llsc_resv_monitor.sv
module test_llsc_resv_monitor;
  localparam logic [31:0] LINE_A = 32'h0000_1040;
  localparam logic [31:0] LINE_B = 32'h0000_2360;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, lineOwned, snoopValid, snoopRfo, evictValid, clearResv;
  logic [1:0] reqOp;
  logic [31:0] reqAddr, snoopAddr, evictAddr;
  logic wrEnable, scValid, scResult, busUpgrade, resvValid;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  llsc_resv_monitor i_llsc_resv_monitor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .lineOwned(lineOwned), .snoopValid(snoopValid), .snoopRfo(snoopRfo),
    .snoopAddr(snoopAddr), .evictValid(evictValid), .evictAddr(evictAddr),
    .clearResv(clearResv), .wrEnable(wrEnable), .scValid(scValid),
    .scResult(scResult), .busUpgrade(busUpgrade), .resvValid(resvValid)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; reqOp = 0; reqAddr = 0; lineOwned = 1;
    snoopValid = 0; snoopRfo = 0; snoopAddr = 0;
    evictValid = 0; evictAddr = 0; clearResv = 0;
  endtask

  // Drive one request at a falling edge; outputs are combinational, sampled 2 ns later
  task automatic drive(input logic [1:0] op, input logic [31:0] addr, input logic own);
    idle();
    reqValid = 1; reqOp = op; reqAddr = addr; lineOwned = own;
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    chk("R9 reset clears reservation", resvValid, 1'b0);
    @(negedge clk);
    drive(2'd3, LINE_A, 1'b1); #2;
    chk("R5 sc without reservation fails", scResult, 1'b0);
    chk("R4 scValid on sc", scValid, 1'b1);
    chk("R4 failed sc no write", wrEnable, 1'b0);

    // Exhaustive sweep after a fresh load-linked to LINE_A
    for (int op = 0; op < 4; op++)
      for (int lineSel = 0; lineSel < 2; lineSel++)
        for (int word = 0; word < 2; word++)
          for (int snp = 0; snp < 4; snp++)
            for (int ev = 0; ev < 3; ev++)
              for (int clr = 0; clr < 2; clr++)
                for (int own = 0; own < 2; own++) begin
                  logic [31:0] addr;
                  logic killOld, killNew, expSc, expWr, expValid, reqOnA, expProbe;
                  // setup load-linked
                  @(negedge clk);
                  drive(2'd2, LINE_A + 32'd8, 1'b1); #2;
                  chk("R1 ll does not write", wrEnable, 1'b0);
                  @(negedge clk);
                  chk("R2 ll sets reservation", resvValid, 1'b1);
                  // stimulus under test
                  addr = (lineSel == 0 ? LINE_A : LINE_B) + (word == 0 ? 32'd0 : 32'd28);
                  reqOnA = (lineSel == 0);
                  drive(op[1:0], addr, own[0]);
                  // snoop: 0 none, 1 RFO to A line, 2 RFO to B line, 3 plain read to A line
                  snoopValid = (snp != 0);
                  snoopRfo   = (snp == 1 || snp == 2);
                  snoopAddr  = (snp == 2 ? LINE_B : LINE_A) + 32'd4;
                  // eviction: 0 none, 1 A line, 2 B line
                  evictValid = (ev != 0);
                  evictAddr  = (ev == 2 ? LINE_B : LINE_A) + 32'd16;
                  clearResv  = clr[0];
                  killOld = clr[0] || snp == 1 || ev == 1;
                  killNew = clr[0] || (snp == 1 && reqOnA) || (snp == 2 && !reqOnA)
                                   || (ev == 1 && reqOnA) || (ev == 2 && !reqOnA);
                  expSc = (op == 3) && reqOnA && !killOld;
                  expWr = (op == 1) || expSc;
                  if (op == 2)      expValid = !killNew;
                  else if (op == 3) expValid = 1'b0;
                  else              expValid = !killOld;
                  #2;
                  chk("R4 scValid", scValid, op == 3);
                  if (op == 3) begin
                    if (killOld) chk("R8 clearing event beats sc", scResult, 1'b0);
                    else         chk("R3 sc line match", scResult, expSc);
                  end else chk("R1 plain/ll no sc result", scResult, 1'b0);
                  chk("R1 R3 write enable", wrEnable, expWr);
                  chk("R11 upgrade strobe", busUpgrade, expWr && !own[0]);
                  @(negedge clk);
                  if (op == 3)        chk("R6 sc clears reservation", resvValid, 1'b0);
                  else if (snp == 1 && op != 2) chk("R7 rfo hit drops", resvValid, 1'b0);
                  else if (ev == 1 && op != 2)  chk("R9 eviction drops", resvValid, 1'b0);
                  else if (clr == 1)            chk("R9 clear pulse drops", resvValid, 1'b0);
                  else if (op == 2)             chk("R8 R10 ll new reservation", resvValid, expValid);
                  else                          chk("R7 R1 reservation kept", resvValid, expValid);
                  // probe tag: sc to LINE_A succeeds only if reservation is on LINE_A
                  expProbe = expValid && (op != 2 || reqOnA);
                  drive(2'd3, LINE_A + 32'd20, 1'b1); #2;
                  if (op == 2) chk("R10 ll replaces tag", scResult, expProbe);
                  else         chk("R3 tag survives", scResult, expProbe);
                  chk("R11 owned line no upgrade", busUpgrade, 1'b0);
                end

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired R1 got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule